// File: doc/BRIEF.md
# Transmit Descriptor Ring Sequencer

This block services a circular list of fixed-size transmit descriptors in memory. Each descriptor is 128 bytes long. Its first 64-bit word is a command header. Inline payload bytes and up to three gather-pointer words follow the header. Software places descriptors in the ring and moves a write pointer forward. The sequencer notices that the ring is not empty and reads the header. It then presents the packet to a MAC transmit datapath as an ordered stream of byte segments. A segment is either a span inside the descriptor itself or a buffer named by a gather pointer.

When the datapath reports that the packet has finished, the sequencer writes a status word over the header. It then steps its read pointer forward, modulo the ring size. A per-packet interrupt pulse is raised if the header asked for one, and a separate pulse marks the moment the ring drains. An abort report against a descriptor that asked for it stops the sequencer. The stop holds until reset.

Top module: `txRingSeq`

## Requirements
- R1: While reset is asserted and just after it, rdPtr is 0, and memRdReq, memWrEn, segValid, txIrq and txEmpty are all low.
- R2: The descriptor for read pointer p sits at byte address {ringBase, 13'b0} + 128*p. Nothing is fetched while rdPtr equals wrPtr.
- R3: In the header, bits 22:16 are the inline byte offset and bits 15:0 are the inline byte count minus one. A non-zero offset produces one inline segment. Its segAddr is the descriptor address plus the offset, its segLen is bits 15:0, and segInline is 1. An offset of 0 means the descriptor carries no inline data.
- R4: Header bits 25, 26 and 27 are the valid flags of gather pointers 1, 2 and 3. Pointer k is read from the descriptor address plus 8*k. It produces a segment with segAddr = {word[31:3], 3'b000}, segLen = word[47:32] and segInline = 0.
- R5: Segments leave in a fixed order: inline first, then pointers 1, 2 and 3. Any absent part is skipped.
- R6: A presented segment holds its valid, address and length until it is taken with segReady high.
- R7: A doneValid that arrives after the last segment causes one write to the descriptor address. The written word has bit 63 set, the retry count in bits 19:16, and the total byte count of the packet's segments in bits 15:0. All other bits are zero.
- R8: After the status write, rdPtr moves forward by one. It wraps from ENTRIES-1 to 0.
- R9: txIrq pulses for one cycle after the status write of a packet whose header bit 24 is set. It does not pulse for any other packet.
- R10: txEmpty pulses for one cycle when the advanced rdPtr equals wrPtr.
- R11: A doneValid that arrives while no packet is waiting for completion has no effect.
- R12: Completion with doneAbort high stops the sequencer for good if header bit 23 is set. In that case there is no status write, no pointer step, no interrupt and no further memory read. If bit 23 is clear, the packet completes normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ringBase | input | 19 | Ring base, address bits 31:13 |
| wrPtr | input | 16 | Software write pointer |
| rdPtr | output | 16 | Hardware read pointer |
| memRdReq | output | 1 | Word read request, held until memRdValid |
| memRdAddr | output | 32 | Read byte address |
| memRdValid | input | 1 | Read data returned |
| memRdData | input | 64 | Read data word |
| memWrEn | output | 1 | Status word write strobe |
| memWrAddr | output | 32 | Write byte address |
| memWrData | output | 64 | Status word |
| segValid | output | 1 | Segment presented |
| segReady | input | 1 | Segment accepted |
| segAddr | output | 32 | Segment byte address |
| segLen | output | 16 | Segment byte count minus one |
| segInline | output | 1 | Segment lies inside the descriptor |
| doneValid | input | 1 | Packet completion report |
| doneAbort | input | 1 | Completion was an abort |
| doneRetries | input | 4 | Collision retry count |
| txIrq | output | 1 | Per-packet interrupt pulse |
| txEmpty | output | 1 | Ring drained pulse |

## Verification
The step of rdPtr from the last entry back to zero is the hardest condition to reach from the ports. It only happens after a full ring's worth of completions. The bench reaches it by filling the rest of the ring with descriptors that carry no segments and completing each of them in turn. It checks that txEmpty fires only at the final step. The halting abort is placed last in the bench because nothing short of reset recovers from it.

// File: rtl/txRingPkg.sv
package txRingPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_NEXT,
    ST_PTR,
    ST_SEG,
    ST_WAIT,
    ST_WB,
    ST_HALT
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       loadHdr;
    logic       loadPtr;
    logic       addLen;
    logic       captureDone;
    logic       advance;
    logic [1:0] wordSel;
  } strobe_t;

endpackage

// File: rtl/txRingCtrl.sv
module txRingCtrl
  import txRingPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ringEmpty,
  input  logic       hasInline,
  input  logic [2:0] ptrValid,
  input  logic       termFlag,
  input  logic       memRdValid,
  input  logic       segReady,
  input  logic       doneValid,
  input  logic       doneAbort,
  output logic       memRdReq,
  output logic       memWrEn,
  output logic       segValid,
  output logic       segInline,
  output strobe_t    stb
);

  seqState_t stateQ, stateD;
  logic [2:0] idxQ, idxD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      idxQ   <= '0;
    end else begin
      stateQ <= stateD;
      idxQ   <= idxD;
    end
  end

  always_comb begin
    stateD    = stateQ;
    idxD      = idxQ;
    stb       = '0;
    memRdReq  = 1'b0;
    memWrEn   = 1'b0;
    segValid  = 1'b0;
    case (stateQ)
      ST_IDLE: if (!ringEmpty) stateD = ST_HDR;
      ST_HDR: begin
        memRdReq = 1'b1;
        if (memRdValid) begin
          stb.loadHdr = 1'b1;
          idxD        = '0;
          stateD      = ST_NEXT;
        end
      end
      ST_NEXT: begin
        // slot 0 is inline, slots 1..3 are gather pointers, 4 is finished
        if (idxQ == 3'd0) begin
          if (hasInline) stateD = ST_SEG;
          else           idxD   = 3'd1;
        end else if (idxQ == 3'd4) begin
          stateD = ST_WAIT;
        end else if (ptrValid[2'(idxQ[1:0] - 2'd1)]) begin
          stateD = ST_PTR;
        end else begin
          idxD = idxQ + 3'd1;
        end
      end
      ST_PTR: begin
        memRdReq    = 1'b1;
        stb.wordSel = idxQ[1:0];
        if (memRdValid) begin
          stb.loadPtr = 1'b1;
          stateD      = ST_SEG;
        end
      end
      ST_SEG: begin
        segValid = 1'b1;
        if (segReady) begin
          stb.addLen = 1'b1;
          idxD       = idxQ + 3'd1;
          stateD     = ST_NEXT;
        end
      end
      ST_WAIT: if (doneValid) begin
        stb.captureDone = 1'b1;
        stateD = (doneAbort && termFlag) ? ST_HALT : ST_WB;
      end
      ST_WB: begin
        memWrEn     = 1'b1;
        stb.advance = 1'b1;
        stateD      = ST_IDLE;
      end
      default: ;
    endcase
  end

  assign segInline = (idxQ == 3'd0);

  AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    segValid && !segReady |=> segValid); // R6

  AST_WB_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> $past(doneValid)); // R7

  AST_NO_BOTH_PORTS: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> !segValid && !memRdReq); // R7

endmodule

// File: rtl/txRingDp.sv
module txRingDp
  import txRingPkg::*;
#(
  parameter int ENTRIES    = 64,
  parameter int DESC_BYTES = 128,
  parameter int ADDR_W     = 32,
  parameter int PTR_W      = 16,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int OFF_W     = $clog2(DESC_BYTES),
  localparam int BASE_W    = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [BASE_W-1:0] ringBase,
  input  logic [PTR_W-1:0]  wrPtr,
  input  logic [63:0]       memRdData,
  input  logic [3:0]        doneRetries,
  output logic [PTR_W-1:0]  rdPtr,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [63:0]       memWrData,
  output logic [ADDR_W-1:0] segAddr,
  output logic [15:0]       segLen,
  output logic              ringEmpty,
  output logic              hasInline,
  output logic [2:0]        ptrValid,
  output logic              termFlag,
  output logic              txIrq,
  output logic              txEmpty
);

  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(ENTRIES - 1);

  logic [PTR_W-1:0]  rdPtrQ, ptrNext;
  logic [ADDR_W-1:0] descAddr, segAddrQ;
  logic [15:0]       segLenQ, totLenQ;
  logic [6:0]        offsetQ;
  logic [2:0]        validQ;
  logic              irqReqQ, termQ, txIrqQ, txEmptyQ;
  logic [3:0]        retryQ;
  logic              unusedBits;

  assign descAddr  = {ringBase, rdPtrQ[IDX_W-1:0], OFF_W'(0)};
  assign memRdAddr = descAddr + ADDR_W'({stb.wordSel, 3'b000});
  assign memWrAddr = descAddr;
  assign memWrData = {1'b1, 43'd0, retryQ, totLenQ};
  assign ptrNext   = (rdPtrQ == LAST_PTR) ? '0 : rdPtrQ + 1'b1;
  assign unusedBits = ^{memRdData[63:48], memRdData[2:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtrQ   <= '0;
      segAddrQ <= '0;
      segLenQ  <= '0;
      totLenQ  <= '0;
      offsetQ  <= '0;
      validQ   <= '0;
      irqReqQ  <= 1'b0;
      termQ    <= 1'b0;
      retryQ   <= '0;
      txIrqQ   <= 1'b0;
      txEmptyQ <= 1'b0;
    end else begin
      if (stb.loadHdr) begin
        offsetQ  <= memRdData[22:16];
        termQ    <= memRdData[23];
        irqReqQ  <= memRdData[24];
        validQ   <= memRdData[27:25];
        segAddrQ <= descAddr + ADDR_W'(memRdData[22:16]);
        segLenQ  <= memRdData[15:0];
        totLenQ  <= '0;
      end
      if (stb.loadPtr) begin
        segAddrQ <= ADDR_W'({memRdData[31:3], 3'b000});
        segLenQ  <= memRdData[47:32];
      end
      if (stb.addLen)      totLenQ <= totLenQ + segLenQ + 16'd1;
      if (stb.captureDone) retryQ  <= doneRetries;
      if (stb.advance)     rdPtrQ  <= ptrNext;
      txIrqQ   <= stb.advance && irqReqQ;
      txEmptyQ <= stb.advance && (ptrNext == wrPtr);
    end
  end

  assign rdPtr     = rdPtrQ;
  assign segAddr   = segAddrQ;
  assign segLen    = segLenQ;
  assign ringEmpty = (rdPtrQ == wrPtr);
  assign hasInline = (offsetQ != 7'd0);
  assign ptrValid  = validQ;
  assign termFlag  = termQ;
  assign txIrq     = txIrqQ;
  assign txEmpty   = txEmptyQ;

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    rdPtrQ <= LAST_PTR); // R8

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (rdPtrQ != $past(rdPtrQ)) |->
      (rdPtrQ == (($past(rdPtrQ) == LAST_PTR) ? '0 : $past(rdPtrQ) + 1'b1))); // R8

  AST_IRQ_AFTER_WB: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |-> $past(stb.advance)); // R9

endmodule

// File: rtl/txRingSeq.sv
module txRingSeq
  import txRingPkg::*;
#(
  parameter int ENTRIES    = 64,
  parameter int DESC_BYTES = 128,
  parameter int ADDR_W     = 32,
  parameter int PTR_W      = 16,
  localparam int BASE_W    = ADDR_W - $clog2(ENTRIES) - $clog2(DESC_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BASE_W-1:0] ringBase,
  input  logic [PTR_W-1:0]  wrPtr,
  output logic [PTR_W-1:0]  rdPtr,
  output logic              memRdReq,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic              memRdValid,
  input  logic [63:0]       memRdData,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [63:0]       memWrData,
  output logic              segValid,
  input  logic              segReady,
  output logic [ADDR_W-1:0] segAddr,
  output logic [15:0]       segLen,
  output logic              segInline,
  input  logic              doneValid,
  input  logic              doneAbort,
  input  logic [3:0]        doneRetries,
  output logic              txIrq,
  output logic              txEmpty
);

  strobe_t    stb;
  logic       ringEmpty, hasInline, termFlag;
  logic [2:0] ptrValid;

  txRingCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ringEmpty  (ringEmpty),
    .hasInline  (hasInline),
    .ptrValid   (ptrValid),
    .termFlag   (termFlag),
    .memRdValid (memRdValid),
    .segReady   (segReady),
    .doneValid  (doneValid),
    .doneAbort  (doneAbort),
    .memRdReq   (memRdReq),
    .memWrEn    (memWrEn),
    .segValid   (segValid),
    .segInline  (segInline),
    .stb        (stb)
  );

  txRingDp #(
    .ENTRIES    (ENTRIES),
    .DESC_BYTES (DESC_BYTES),
    .ADDR_W     (ADDR_W),
    .PTR_W      (PTR_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .ringBase    (ringBase),
    .wrPtr       (wrPtr),
    .memRdData   (memRdData),
    .doneRetries (doneRetries),
    .rdPtr       (rdPtr),
    .memRdAddr   (memRdAddr),
    .memWrAddr   (memWrAddr),
    .memWrData   (memWrData),
    .segAddr     (segAddr),
    .segLen      (segLen),
    .ringEmpty   (ringEmpty),
    .hasInline   (hasInline),
    .ptrValid    (ptrValid),
    .termFlag    (termFlag),
    .txIrq       (txIrq),
    .txEmpty     (txEmpty)
  );

  AST_SEG_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    segValid && !segReady |=> $stable(segAddr) && $stable(segLen)); // R6

  AST_IDLE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    $past(rdPtr == wrPtr) && $stable(rdPtr) && $past(!memRdReq && !segValid)
      && $past(!memWrEn) |-> 1'b1 ? !memWrEn : 1'b1); // R2

endmodule

// File: tb/txRingSeq_tb.sv
module txRingSeq_tb;

  typedef struct packed {
    logic        abort;
    logic        term;
    logic [2:0]  mask;
    logic        irq;
    logic [6:0]  off;
    logic [3:0]  retry;
    logic [15:0] lenM1;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 1'b0, 3'b000, 1'b1, 7'd32, 4'd0,  16'd39},
    '{1'b0, 1'b0, 3'b111, 1'b0, 7'd0,  4'd3,  16'd0},
    '{1'b0, 1'b0, 3'b101, 1'b1, 7'd8,  4'd15, 16'd119},
    '{1'b0, 1'b0, 3'b010, 1'b0, 7'd0,  4'd1,  16'd5},
    '{1'b0, 1'b0, 3'b100, 1'b1, 7'd24, 4'd2,  16'd0},
    '{1'b0, 1'b0, 3'b000, 1'b0, 7'd0,  4'd0,  16'd0},
    '{1'b1, 1'b0, 3'b001, 1'b1, 7'd16, 4'd7,  16'd63}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [18:0] ringBase = 19'd1;
  logic [15:0] wrPtr = '0;
  logic [15:0] rdPtr;
  logic        memRdReq, memRdValid, memWrEn;
  logic [31:0] memRdAddr, memWrAddr;
  logic [63:0] memRdData, memWrData;
  logic        segValid, segReady, segInline;
  logic [31:0] segAddr;
  logic [15:0] segLen;
  logic        doneValid = 1'b0, doneAbort = 1'b0;
  logic [3:0]  doneRetries = '0;
  logic        txIrq, txEmpty;

  always #2 clk = ~clk;

  txRingSeq u_dut (
    .clk(clk), .rstN(rstN), .ringBase(ringBase), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .memRdReq(memRdReq), .memRdAddr(memRdAddr), .memRdValid(memRdValid),
    .memRdData(memRdData), .memWrEn(memWrEn), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .segValid(segValid), .segReady(segReady),
    .segAddr(segAddr), .segLen(segLen), .segInline(segInline),
    .doneValid(doneValid), .doneAbort(doneAbort), .doneRetries(doneRetries),
    .txIrq(txIrq), .txEmpty(txEmpty)
  );

  // memory model: one 8 KB window, one cycle read latency
  logic [63:0] mem [1024];
  always @(posedge clk) begin
    if (!rstN) memRdValid <= 1'b0;
    else memRdValid <= memRdReq && !memRdValid;
    memRdData <= mem[memRdAddr[12:3]];
    if (memWrEn) mem[memWrAddr[12:3]] <= memWrData;
  end

  int vecs = 0, fails = 0, cyc = 0;
  int capCount = 0, irqCnt = 0, emptyCnt = 0, wrCnt = 0, rdReqCnt = 0;
  logic [31:0] capAddr [64];
  logic [15:0] capLen  [64];
  logic        capInl  [64];
  logic [31:0] expAddr [8];
  logic [15:0] expLen  [8];
  logic        expInl  [8];

  always @(negedge clk) begin
    cyc = cyc + 1;
    segReady = (cyc % 3) != 1;
    if (rstN && segValid && segReady && capCount < 64) begin
      capAddr[capCount] = segAddr;
      capLen[capCount]  = segLen;
      capInl[capCount]  = segInline;
      capCount = capCount + 1;
    end
    if (txIrq)    irqCnt++;
    if (txEmpty)  emptyCnt++;
    if (memWrEn)  wrCnt++;
    if (memRdReq) rdReqCnt++;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulseDone(input logic ab, input logic [3:0] rt);
    @(negedge clk);
    doneValid = 1'b1; doneAbort = ab; doneRetries = rt;
    @(negedge clk);
    doneValid = 1'b0; doneAbort = 1'b0; doneRetries = '0;
  endtask

  function automatic logic [63:0] hdrWord(input vec_t v);
    return {36'd0, v.mask[2], v.mask[1], v.mask[0], v.irq, v.term, v.off, v.lenM1};
  endfunction

  function automatic logic [31:0] gAddr(input int k, input int i);
    return 32'h1000_0000 + 32'(k) * 32'h100 + 32'(i) * 32'h1000;
  endfunction

  task automatic runPacket(input int i);
    vec_t v;
    int n, start, irq0, emp0;
    logic [15:0] tot;
    v = VEC[i];
    mem[i*16] = hdrWord(v);
    for (int k = 1; k <= 3; k++)
      mem[i*16+k] = {16'd0, 16'(10*k + i), gAddr(k, i)};
    n = 0; tot = '0;
    if (v.off != 0) begin   // R3 inline first
      expAddr[n] = 32'h2000 + 32'(i*128) + 32'(v.off);
      expLen[n] = v.lenM1; expInl[n] = 1'b1;
      tot = tot + v.lenM1 + 16'd1; n++;
    end
    for (int k = 1; k <= 3; k++) if (v.mask[k-1]) begin   // R4 R5
      expAddr[n] = gAddr(k, i); expLen[n] = 16'(10*k + i); expInl[n] = 1'b0;
      tot = tot + 16'(10*k + i) + 16'd1; n++;
    end
    start = capCount; irq0 = irqCnt; emp0 = emptyCnt;
    @(negedge clk);
    wrPtr = 16'(i + 1);
    for (int w = 0; w < 400 && capCount - start < n; w++) @(negedge clk);
    repeat (10) @(negedge clk);
    pulseDone(v.abort, v.retry);
    repeat (4) @(negedge clk);
    chk("R5 segment count", 64'(capCount - start), 64'(n));
    for (int s = 0; s < n; s++) begin
      chk(expInl[s] ? "R3 inline addr" : "R4 gather addr", 64'(capAddr[start+s]), 64'(expAddr[s]));
      chk("R5 segment len", 64'(capLen[start+s]), 64'(expLen[s]));
      chk("R5 segment kind", 64'(capInl[start+s]), 64'(expInl[s]));
    end
    chk(v.abort ? "R12 abort w/o stop" : "R7 status word", mem[i*16],
        {1'b1, 43'd0, v.retry, tot});
    chk("R8 rdPtr step", 64'(rdPtr), 64'(i + 1));
    chk("R9 irq pulses", 64'(irqCnt - irq0), 64'(v.irq));
    chk("R10 empty pulse", 64'(emptyCnt - emp0), 64'd1);
  endtask

  initial begin
    for (int a = 0; a < 1024; a++) mem[a] = '0;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 rdPtr", 64'(rdPtr), 64'd0);
    chk("R1 outputs", {59'd0, memRdReq, memWrEn, segValid, txIrq, txEmpty}, 64'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after reset", {59'd0, memRdReq, memWrEn, segValid, txIrq, txEmpty}, 64'd0);
    // R11 completion with nothing pending; R2 idle while empty
    pulseDone(1'b0, 4'd9);
    repeat (4) @(negedge clk);
    chk("R11 rdPtr unchanged", 64'(rdPtr), 64'd0);
    chk("R11 no write", 64'(wrCnt), 64'd0);
    chk("R11 no irq", 64'(irqCnt), 64'd0);
    chk("R2 no fetch when empty", 64'(rdReqCnt), 64'd0);

    for (int i = 0; i < NVEC; i++) runPacket(i);

    // R8 R10 wrap: fill the rest of the ring with empty descriptors
    begin
      int emp0;
      for (int e = NVEC; e < 64; e++) mem[e*16] = '0;
      emp0 = emptyCnt;
      @(negedge clk);
      wrPtr = 16'd0;
      for (int e = NVEC; e < 64; e++) begin
        repeat (12) @(negedge clk);
        pulseDone(1'b0, 4'd0);
        repeat (2) @(negedge clk);
      end
      repeat (4) @(negedge clk);
      chk("R8 wrap to zero", 64'(rdPtr), 64'd0);
      chk("R10 single empty pulse", 64'(emptyCnt - emp0), 64'd1);
      chk("R7 empty packet status", mem[63*16], {1'b1, 63'd0});
    end

    // R12 abort on a descriptor that asks to stop
    begin
      vec_t h;
      int irq0, wr0, rd0, c0;
      h = '{1'b1, 1'b1, 3'b000, 1'b1, 7'd16, 4'd5, 16'd7};
      mem[0] = hdrWord(h);
      c0 = capCount; irq0 = irqCnt; wr0 = wrCnt;
      @(negedge clk);
      wrPtr = 16'd1;
      for (int w = 0; w < 400 && capCount == c0; w++) @(negedge clk);
      repeat (10) @(negedge clk);
      pulseDone(1'b1, 4'd5);
      repeat (4) @(negedge clk);
      rd0 = rdReqCnt;
      repeat (20) @(negedge clk);
      chk("R12 halt rdPtr", 64'(rdPtr), 64'd0);
      chk("R12 header kept", mem[0], hdrWord(h));
      chk("R12 no irq", 64'(irqCnt - irq0), 64'd0);
      chk("R12 no write", 64'(wrCnt - wr0), 64'd0);
      chk("R12 no further reads", 64'(rdReqCnt - rd0), 64'd0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual cycles %0d expected fewer than %0d", cyc, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule